// File: doc/BRIEF.md
# Multiprocessor UART receiver with address filtering

This block receives asynchronous serial frames on a single line that it oversamples sixteen times per bit. Two frame lengths are selectable: a 10-bit frame (start, eight data bits sent least significant bit first, stop) and an 11-bit frame (start, eight data bits, a ninth bit, stop). Each accepted frame places its byte in `rx_data`. The ninth bit, or the stop bit in the 10-bit frame, goes to `rx_ninth`. The receive flag `ri` is then raised.

On multiprocessor links, the controlling side sets `mp_en`. With `mp_en` set, the block compares each address frame against two programmable addresses, one for this node and one for broadcast, and raises `ri` only on a hit. A framing-error option (`fe_mode`) moves the moment `ri` rises from the last data bit to the stop-bit sample. A stop bit sampled low always sets the sticky flag `fe`. Both flags are cleared only by their own one-cycle clear strobes.

Top module: `mp_uart_rx`

## Requirements
- R1: With `frame11`=0 a frame is start, 8 data bits LSB first, stop; with `frame11`=1 a ninth bit follows the data before the stop. An accepted frame loads the byte into `rx_data`.
- R2: The line is oversampled 16 times per bit. Each bit is decided by a majority of three samples taken around mid-bit. A low pulse that has returned high by mid-bit of the start bit is rejected: no frame is received, and the next real frame is received intact.
- R3: With `fe_mode`=0, `ri` rises after the sample of the last data bit (D7 in 10-bit frames, the ninth bit in 11-bit frames), before the stop bit is sampled. With `fe_mode`=1, `ri` rises only after the stop-bit sample.
- R4: A stop bit sampled low sets `fe`. A later frame with a valid stop bit leaves `fe` set. Only `clr_fe` clears it.
- R5: With `mp_en`=0 every complete frame sets `ri`, whatever its content.
- R6: In 11-bit frames with `mp_en`=1, `ri` is set only when the ninth bit is 1 and the byte matches.
- R7: In 10-bit frames with `mp_en`=1, `ri` is set only when the byte matches and the stop bit is 1. The decision waits for the stop sample.
- R8: A byte matches when it equals `node_addr` or `bcast_addr`. Both are read at the decision point, so a new value applies from the next frame.
- R9: While `ri` is set and not being cleared, a new frame is discarded: `rx_data`, `rx_ninth` and `ri` keep their values.
- R10: `clr_ri` and `clr_fe` clear their flag on the next clock edge. If a frame sets a flag in the same cycle as its clear, the flag ends up set. Reset leaves `ri`, `fe`, `rx_data` and `rx_ninth` at 0.
- R11: `rx_ninth` holds the ninth bit in 11-bit frames and the stop bit in 10-bit frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| frame11 | input | 1 | 1 selects the 11-bit frame |
| fe_mode | input | 1 | 1 moves `ri` to the stop-bit sample |
| mp_en | input | 1 | Multiprocessor address filtering enable |
| node_addr | input | 8 | Own address of this node |
| bcast_addr | input | 8 | Broadcast address |
| clr_ri | input | 1 | One-cycle clear strobe for `ri` |
| clr_fe | input | 1 | One-cycle clear strobe for `fe` |
| rx_data | output | 8 | Last accepted byte |
| rx_ninth | output | 1 | Ninth bit, or stop bit in 10-bit frames |
| ri | output | 1 | Receive flag |
| fe | output | 1 | Sticky framing-error flag |

## Verification
Each bit is decided about nine or ten oversampling ticks after its edge on the line. The two-stage synchronizer adds two cycles, and the framer event register and the flag register add one cycle each. A result is therefore visible well inside the same bit time. The bench reads end-of-frame results two full bit times after the stop bit is driven. It probes the position of `ri` a quarter of the way into the stop bit: by then the last data sample has landed, and the stop sample has not yet been taken. Clear strobes are checked one edge after the strobe.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP
  } rx_state_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import mp_uart_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             rxd,
  input  logic             frame11,
  output logic             ev_last,
  output logic             ev_stop,
  output logic [DBITS-1:0] data,
  output logic             ninth,
  output logic             stop_bit
);
  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(DBITS + 1);
  localparam int S_M = OSR / 2;
  localparam int S_A = S_M - 1;
  localparam int S_B = S_M + 1;

  rx_state_t      st;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  bidx;
  logic           v0, v1, vote;

  assign vote = (v0 & v1) | (v0 & rxd) | (v1 & rxd);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      v0       <= 1'b1;
      v1       <= 1'b1;
      data     <= '0;
      ninth    <= 1'b0;
      stop_bit <= 1'b1;
      ev_last  <= 1'b0;
      ev_stop  <= 1'b0;
    end else begin
      ev_last <= 1'b0;
      ev_stop <= 1'b0;
      if (tick) begin
        if (st == ST_IDLE) begin
          if (!rxd) begin
            st  <= ST_START;
            cnt <= '0;
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(S_A)) v0 <= rxd;
          if (cnt == CW'(S_M)) v1 <= rxd;
          if (cnt == CW'(S_B)) begin
            case (st)
              ST_START: if (vote) st <= ST_IDLE;
              ST_DATA: begin
                data <= {vote, data[DBITS-1:1]};
                bidx <= bidx + 1'b1;
                if (!frame11 && bidx == BW'(DBITS - 1)) ev_last <= 1'b1;
              end
              ST_NINTH: begin
                ninth   <= vote;
                ev_last <= 1'b1;
              end
              ST_STOP: begin
                stop_bit <= vote;
                ev_stop  <= 1'b1;
                st       <= ST_IDLE;
              end
              default: st <= ST_IDLE;
            endcase
          end
          if (cnt == CW'(OSR - 1)) begin
            case (st)
              ST_START: begin
                st   <= ST_DATA;
                bidx <= '0;
              end
              ST_DATA:  if (bidx == BW'(DBITS)) st <= frame11 ? ST_NINTH : ST_STOP;
              ST_NINTH: st <= ST_STOP;
              default:  ;
            endcase
          end
        end
      end
    end
  end

  AST_STOP_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    ev_stop |-> (st == ST_IDLE)); // R1
  AST_EVENTS_APART: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_last, ev_stop})); // R3
endmodule

// File: rtl/rx_accept.sv
module rx_accept #(
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_last,
  input  logic             ev_stop,
  input  logic [DBITS-1:0] data,
  input  logic             ninth,
  input  logic             stop_bit,
  input  logic             frame11,
  input  logic             fe_mode,
  input  logic             mp_en,
  input  logic [DBITS-1:0] node_addr,
  input  logic [DBITS-1:0] bcast_addr,
  input  logic             clr_ri,
  input  logic             clr_fe,
  output logic [DBITS-1:0] rx_data,
  output logic             rx_ninth,
  output logic             ri,
  output logic             fe
);
  logic late, decide, hit, addr_ok, busy, load, fe_set, took;

  assign late    = fe_mode | (mp_en & ~frame11);
  assign decide  = late ? ev_stop : ev_last;
  assign hit     = (data == node_addr) | (data == bcast_addr);
  assign addr_ok = ~mp_en | (hit & (frame11 ? ninth : stop_bit));
  assign busy    = ri & ~clr_ri;
  assign load    = decide & addr_ok & ~busy;
  assign fe_set  = ev_stop & ~stop_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_ninth <= 1'b0;
      ri       <= 1'b0;
      fe       <= 1'b0;
      took     <= 1'b0;
    end else begin
      if (load) begin
        rx_data  <= data;
        rx_ninth <= frame11 ? ninth : stop_bit;
        ri       <= 1'b1;
      end else if (clr_ri) begin
        ri <= 1'b0;
      end
      if (ev_stop && !frame11 && took) rx_ninth <= stop_bit;
      if (load && !ev_stop) took <= 1'b1;
      else if (ev_stop)     took <= 1'b0;
      if (fe_set)      fe <= 1'b1;
      else if (clr_fe) fe <= 1'b0;
    end
  end

  AST_FE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fe && !clr_fe) |=> fe); // R4
  AST_FE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_fe && !fe_set) |=> !fe); // R10
  AST_RI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ri && !clr_ri) |=> ri); // R9
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ri && !clr_ri) |=> $stable(rx_data)); // R9
  AST_NO_MISS_SET: assert property (@(posedge clk) disable iff (rst)
    (fe_set && clr_fe) |=> fe); // R10
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int OSR   = 16,
  parameter int DBITS = 8,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick16,
  input  logic             rxd,
  input  logic             frame11,
  input  logic             fe_mode,
  input  logic             mp_en,
  input  logic [DBITS-1:0] node_addr,
  input  logic [DBITS-1:0] bcast_addr,
  input  logic             clr_ri,
  input  logic             clr_fe,
  output logic [DBITS-1:0] rx_data,
  output logic             rx_ninth,
  output logic             ri,
  output logic             fe
);
  logic             rxd_s, ev_last, ev_stop, ninth, stop_bit;
  logic [DBITS-1:0] data;

  rx_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(rxd_s)
  );

  rx_framer #(.OSR(OSR), .DBITS(DBITS)) u_framer (
    .clk(clk), .rst(rst), .tick(tick16), .rxd(rxd_s), .frame11(frame11),
    .ev_last(ev_last), .ev_stop(ev_stop), .data(data), .ninth(ninth),
    .stop_bit(stop_bit)
  );

  rx_accept #(.DBITS(DBITS)) u_accept (
    .clk(clk), .rst(rst), .ev_last(ev_last), .ev_stop(ev_stop), .data(data),
    .ninth(ninth), .stop_bit(stop_bit), .frame11(frame11), .fe_mode(fe_mode),
    .mp_en(mp_en), .node_addr(node_addr), .bcast_addr(bcast_addr),
    .clr_ri(clr_ri), .clr_fe(clr_fe), .rx_data(rx_data), .rx_ninth(rx_ninth),
    .ri(ri), .fe(fe)
  );
endmodule

// File: tb/tb_mp_uart_rx.sv
module tb_mp_uart_rx;
  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;

  logic clk = 1'b0, rst = 1'b1, tick16 = 1'b0, rxd = 1'b1;
  logic frame11 = 1'b0, fe_mode = 1'b0, mp_en = 1'b0, clr_ri = 1'b0, clr_fe = 1'b0;
  logic [7:0] node_addr = 8'h5A, bcast_addr = 8'hFF;
  logic [7:0] rx_data;
  logic rx_ninth, ri, fe;
  int total = 0, bad = 0, cyc = 0, dcnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mp_uart_rx dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .frame11(frame11),
    .fe_mode(fe_mode), .mp_en(mp_en), .node_addr(node_addr),
    .bcast_addr(bcast_addr), .clr_ri(clr_ri), .clr_fe(clr_fe),
    .rx_data(rx_data), .rx_ninth(rx_ninth), .ri(ri), .fe(fe)
  );

  always @(posedge clk) begin
    dcnt   <= (dcnt == DIV - 1) ? 0 : dcnt + 1;
    tick16 <= (dcnt == DIV - 1);
    cyc    <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bits(logic v, int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_head(logic f11, logic [7:0] d, logic nb);
    bits(1'b0, BIT);
    for (int i = 0; i < 8; i++) bits(d[i], BIT);
    if (f11) bits(nb, BIT);
  endtask

  task automatic send(logic f11, logic [7:0] d, logic nb, logic sb);
    send_head(f11, d, nb);
    bits(sb, BIT);
    bits(1'b1, 2 * BIT);
  endtask

  task automatic clear_flags();
    @(negedge clk);
    clr_ri = 1'b1;
    clr_fe = 1'b1;
    @(negedge clk);
    clr_ri = 1'b0;
    clr_fe = 1'b0;
  endtask

  // fields: f11, fe_mode, mp_en, data[7:0], ninth, stop, exp_ri, exp_fe
  localparam logic [14:0] VEC [11] = '{
    {1'b0, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b1, 1'b0},  // R1 R5 10-bit
    {1'b1, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b0},  // R1 R5 11-bit
    {1'b1, 1'b0, 1'b1, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b0},  // R6 R8 own
    {1'b1, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0},  // R6 R8 broadcast
    {1'b1, 1'b0, 1'b1, 8'h33, 1'b1, 1'b1, 1'b0, 1'b0},  // R6 other node
    {1'b1, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0},  // R6 data frame
    {1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b0},  // R7 match
    {1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b1},  // R7 bad stop
    {1'b0, 1'b0, 1'b1, 8'h12, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 no match
    {1'b0, 1'b1, 1'b0, 8'h81, 1'b0, 1'b0, 1'b1, 1'b1},  // R4 R11
    {1'b1, 1'b0, 1'b0, 8'h77, 1'b1, 1'b0, 1'b1, 1'b1}   // R4 R11
  };

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset ri", ri, 0);
    chk("R10 reset fe", fe, 0);
    chk("R10 reset data", rx_data, 0);
    chk("R10 reset ninth", rx_ninth, 0);

    for (int v = 0; v < 11; v++) begin
      logic [14:0] e;
      e = VEC[v];
      clear_flags();
      frame11 = e[14];
      fe_mode = e[13];
      mp_en   = e[12];
      send(e[14], e[11:4], e[3], e[2]);
      chk($sformatf("R5/R6/R7 vec%0d ri", v), ri, e[1]);
      chk($sformatf("R4 vec%0d fe", v), fe, e[0]);
      if (e[1]) begin
        chk($sformatf("R1 vec%0d data", v), rx_data, e[11:4]);
        chk($sformatf("R11 vec%0d ninth", v), rx_ninth, e[14] ? e[3] : e[2]);
      end
    end

    // R3: position of ri
    clear_flags();
    frame11 = 1; fe_mode = 0; mp_en = 0;
    send_head(1, 8'h4B, 0);
    bits(1'b1, BIT / 4);
    chk("R3 ri at ninth bit", ri, 1);
    bits(1'b1, 3 * BIT);
    clear_flags();
    fe_mode = 1;
    send_head(1, 8'h4B, 0);
    bits(1'b1, BIT / 4);
    chk("R3 ri before stop with fe_mode", ri, 0);
    bits(1'b1, 3 * BIT);
    chk("R3 ri after stop with fe_mode", ri, 1);

    // R4: sticky fe
    clear_flags();
    frame11 = 0; fe_mode = 0;
    send(0, 8'h10, 0, 0);
    clear_flags();
    @(negedge clk);
    clr_fe = 0;
    chk("R10 clr_fe clears", fe, 0);
    send(0, 8'h10, 0, 0);
    chk("R4 fe set", fe, 1);
    clear_flags_ri_only();
    send(0, 8'h20, 0, 1);
    chk("R4 fe stays after good frame", fe, 1);
    chk("R4 good frame data", rx_data, 8'h20);

    // R9: discard while ri set
    send(0, 8'hC3, 0, 1);
    chk("R9 data kept", rx_data, 8'h20);
    chk("R9 ri kept", ri, 1);
    @(negedge clk);
    clr_ri = 1;
    @(negedge clk);
    clr_ri = 0;
    chk("R10 clr_ri clears", ri, 0);

    // R2: glitch on the line
    bits(1'b0, 3 * DIV);
    bits(1'b1, 2 * BIT);
    chk("R2 glitch no frame", ri, 0);
    send(0, 8'h96, 0, 1);
    chk("R2 frame after glitch", rx_data, 8'h96);

    // R8: address change applies to next frame
    clear_flags();
    frame11 = 1; mp_en = 1;
    node_addr = 8'h21;
    send(1, 8'h21, 1, 1);
    chk("R8 new node address", ri, 1);
    clear_flags();
    send(1, 8'h5A, 1, 1);
    chk("R8 old address ignored", ri, 0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic clear_flags_ri_only();
    @(negedge clk);
    clr_ri = 1'b1;
    @(negedge clk);
    clr_ri = 1'b0;
  endtask
endmodule